// File: doc/BRIEF.md
# DMA interrupt status aggregator

This block gathers the interrupt events of a multi-channel DMA engine into one register-visible status view and a single interrupt line. Every channel reports four kinds of event as one-cycle pulses: end of a whole chained transfer, end of one descriptor node that asked to be reported, and two independent fault classes. Each kind has its own bank of per-channel latches, an enable register and a filtered view. A summary word then shows, per channel, whether anything enabled is pending.

Software reads the summary word to find the channels that need service. It reads the filtered views to learn the cause. It acknowledges events by writing ones to the latch banks. The interrupt output is high while any enabled event is latched. After reset every source is disabled, so the line stays low until software opens the enables.

Top module: `dma_irq_aggregator`

## Requirements
- R1: While reset is asserted and right after it, every latch and every enable register holds 0, all mapped registers read 0 and `irq` is low.
- R2: An event pulse on bit i of any of the four event inputs sets latch bit i of that source at the next clock edge, whatever the enable. The latch banks read back at 0x600 (end-of-chain), 0x608 (node), 0x610 (fault A) and 0x618 (fault B).
- R3: The enable registers sit at 0x18, 0x1C, 0x20 and 0x24, in the same source order, and read back what was last written. A 1 in bit i lets channel i's event of that source through.
- R4: The filtered views at 0x04, 0x08, 0x0C and 0x10, in the same source order, read as latch AND enable.
- R5: The summary word at 0x00 has bit i set exactly when channel i has at least one latched and enabled event of any of the four sources.
- R6: `irq` is the OR of all summary bits. It rises in the cycle after an enabled event arrives and falls in the cycle after the last one is cleared or disabled.
- R7: Writing a word to a latch bank clears the bits written as 1 and leaves the bits written as 0 untouched.
- R8: When an event pulse and a clearing write reach the same latch bit in the same cycle, the bit stays set.
- R9: Writes to the summary address, to the filtered views or to any unmapped address change no state. Reads of unmapped addresses return 0.
- R10: Bit i of every register belongs to channel i (bit 15 is the last of 16 channels). Register bits above the channel count read 0, and writes to them are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for `reg_addr` / `reg_wdata` |
| reg_addr | input | 12 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_end | input | 16 | Per-channel pulse: whole chain finished |
| ev_node | input | 16 | Per-channel pulse: reporting node finished |
| ev_fault_a | input | 16 | Per-channel pulse: fault class A |
| ev_fault_b | input | 16 | Per-channel pulse: fault class B |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench targets the cycle in which an event and a clearing write meet on the same bit. A design that lets the clear win would lose an event, and the line would stay low with work pending. It writes ones into enable bits above the channel count and stray values into the read-only views and unmapped addresses. A design that decodes loosely would show ghost bits or corrupt enables. It checks that latching ignores the enable while the summary and line obey it, which catches designs that drop events arriving while disabled. It also checks that clearing one bit does not clear its neighbours in the same or another source.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  localparam int NSRC    = 4;
  localparam int ADDR_W  = 12;

  typedef enum logic [1:0] {
    SRC_END     = 2'd0,
    SRC_NODE    = 2'd1,
    SRC_FAULT_A = 2'd2,
    SRC_FAULT_B = 2'd3
  } src_e;

  localparam logic [ADDR_W-1:0] OFS_SUMMARY   = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_VIEW_BASE = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_EN_BASE   = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_RAW_BASE  = 12'h600;

  // filtered view of source s: word stride
  function automatic logic [ADDR_W-1:0] view_ofs(input int s);
    return OFS_VIEW_BASE + ADDR_W'(4 * s);
  endfunction

  // enable register of source s: word stride
  function automatic logic [ADDR_W-1:0] en_ofs(input int s);
    return OFS_EN_BASE + ADDR_W'(4 * s);
  endfunction

  // latch bank of source s: double-word stride
  function automatic logic [ADDR_W-1:0] raw_ofs(input int s);
    return OFS_RAW_BASE + ADDR_W'(8 * s);
  endfunction

  // next latch value: clear first, then let events win
  function automatic logic [31:0] latch_next(input logic [31:0] cur,
                                             input logic [31:0] clr,
                                             input logic [31:0] ev);
    return (cur & ~clr) | ev;
  endfunction

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import dma_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_sum,
  output logic [NSRC-1:0]   sel_view,
  output logic [NSRC-1:0]   sel_en,
  output logic [NSRC-1:0]   sel_raw
);

  assign sel_sum = (addr == OFS_SUMMARY);

  for (genvar s = 0; s < NSRC; s++) begin : g_dec
    assign sel_view[s] = (addr == view_ofs(s));
    assign sel_en[s]   = (addr == en_ofs(s));
    assign sel_raw[s]  = (addr == raw_ofs(s));
  end

endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_we,
  input  logic              clr_we,
  input  logic [NUM_CH-1:0] wbits,
  input  logic [NUM_CH-1:0] ev,
  output logic [NUM_CH-1:0] raw_q,
  output logic [NUM_CH-1:0] en_q,
  output logic [NUM_CH-1:0] masked
);

  logic [NUM_CH-1:0] clr_bits;
  logic [31:0]       nxt_wide;

  assign clr_bits = clr_we ? wbits : '0;
  assign nxt_wide = dma_irq_pkg::latch_next(32'(raw_q), 32'(clr_bits), 32'(ev));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      en_q  <= '0;
    end else begin
      raw_q <= nxt_wide[NUM_CH-1:0];
      if (en_we) en_q <= wbits;
    end
  end

  assign masked = raw_q & en_q;

endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [11:0]       reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_CH-1:0] ev_end,
  input  logic [NUM_CH-1:0] ev_node,
  input  logic [NUM_CH-1:0] ev_fault_a,
  input  logic [NUM_CH-1:0] ev_fault_b,
  output logic              irq
);

  logic                        sel_sum;
  logic [NSRC-1:0]             sel_view, sel_en, sel_raw;
  logic [NSRC-1:0][NUM_CH-1:0] ev_all, raw_all, mask_all, masked_all;
  logic [NUM_CH-1:0]           summary;
  logic [NUM_CH-1:0]           wbits;
  logic                        unused_wdata;

  assign wbits        = reg_wdata[NUM_CH-1:0];
  assign unused_wdata = ^reg_wdata;

  assign ev_all[SRC_END]     = ev_end;
  assign ev_all[SRC_NODE]    = ev_node;
  assign ev_all[SRC_FAULT_A] = ev_fault_a;
  assign ev_all[SRC_FAULT_B] = ev_fault_b;

  irq_addr_decode u_dec (
    .addr     (reg_addr),
    .sel_sum  (sel_sum),
    .sel_view (sel_view),
    .sel_en   (sel_en),
    .sel_raw  (sel_raw)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    irq_src_bank #(.NUM_CH(NUM_CH)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_we  (reg_wr_en && sel_en[s]),
      .clr_we (reg_wr_en && sel_raw[s]),
      .wbits  (wbits),
      .ev     (ev_all[s]),
      .raw_q  (raw_all[s]),
      .en_q   (mask_all[s]),
      .masked (masked_all[s])
    );
  end

  always_comb begin
    summary = '0;
    for (int s = 0; s < NSRC; s++) summary |= masked_all[s];
  end

  assign irq = |summary;

  always_comb begin
    reg_rdata = '0;
    if (sel_sum) reg_rdata = DATA_W'(summary);
    for (int s = 0; s < NSRC; s++) begin
      if (sel_view[s]) reg_rdata = DATA_W'(masked_all[s]);
      if (sel_en[s])   reg_rdata = DATA_W'(mask_all[s]);
      if (sel_raw[s])  reg_rdata = DATA_W'(raw_all[s]);
    end
  end

endmodule

// File: rtl/dma_irq_aggregator_chk.sv
module dma_irq_aggregator_chk #(
  parameter int NUM_CH = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [11:0]            addr,
  input logic [3:0][NUM_CH-1:0] ev_all,
  input logic [3:0][NUM_CH-1:0] raw_all,
  input logic [3:0][NUM_CH-1:0] mask_all,
  input logic                   irq
);

  logic hits_en, hits_raw;
  assign hits_en  = (addr == 12'h018) || (addr == 12'h01C) ||
                    (addr == 12'h020) || (addr == 12'h024);
  assign hits_raw = (addr == 12'h600) || (addr == 12'h608) ||
                    (addr == 12'h610) || (addr == 12'h618);

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |-> (raw_all == '0 && mask_all == '0 && !irq));

  // R2 and R8: a pulsed bit is set next cycle, even against a clear
  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_all != '0) |=> ((raw_all & $past(ev_all)) == $past(ev_all)));

  // R7: latches move only on events or writes
  a_r7_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ev_all == '0) |=> $stable(raw_all));

  // R3: enables move only on enable writes
  a_r3_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && hits_en) |=> $stable(mask_all));

  // R9: other writes touch nothing
  a_r9_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hits_en && !hits_raw && ev_all == '0) |=>
      ($stable(raw_all) && $stable(mask_all)));

  // R6
  a_r6_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|(raw_all & mask_all)));

endmodule

bind dma_irq_aggregator dma_irq_aggregator_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (reg_wr_en),
  .addr     (reg_addr),
  .ev_all   (ev_all),
  .raw_all  (raw_all),
  .mask_all (mask_all),
  .irq      (irq)
);

// File: tb/dma_irq_aggregator_bench.sv
module dma_irq_aggregator_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] ev_end = '0, ev_node = '0, ev_fault_a = '0, ev_fault_b = '0;
  logic        irq;

  int n_checks = 0;
  int n_fails  = 0;

  logic [15:0] m_raw [4];
  logic [15:0] m_en  [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_aggregator u_dma_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_end(ev_end),
    .ev_node(ev_node), .ev_fault_a(ev_fault_a), .ev_fault_b(ev_fault_b),
    .irq(irq)
  );

  function automatic logic [15:0] m_sum();
    logic [15:0] acc = '0;
    for (int s = 0; s < 4; s++) acc = acc | (m_raw[s] & m_en[s]);
    return acc;
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a)
      12'h000: return {16'h0, m_sum()};
      12'h004: return {16'h0, m_raw[0] & m_en[0]};
      12'h008: return {16'h0, m_raw[1] & m_en[1]};
      12'h00C: return {16'h0, m_raw[2] & m_en[2]};
      12'h010: return {16'h0, m_raw[3] & m_en[3]};
      12'h018: return {16'h0, m_en[0]};
      12'h01C: return {16'h0, m_en[1]};
      12'h020: return {16'h0, m_en[2]};
      12'h024: return {16'h0, m_en[3]};
      12'h600: return {16'h0, m_raw[0]};
      12'h608: return {16'h0, m_raw[1]};
      12'h610: return {16'h0, m_raw[2]};
      12'h618: return {16'h0, m_raw[3]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_reg(input string req, input logic [11:0] a);
    reg_addr = a;
    #1;
    check(req, reg_rdata, m_read(a));
  endtask

  // called just after a falling edge; performs one clock cycle
  task automatic cycle(input logic we, input logic [11:0] a, input logic [31:0] d,
                       input logic [15:0] e0, input logic [15:0] e1,
                       input logic [15:0] e2, input logic [15:0] e3);
    logic [15:0] evs [4];
    evs[0] = e0; evs[1] = e1; evs[2] = e2; evs[3] = e3;
    reg_wr_en = we; reg_addr = a; reg_wdata = d;
    ev_end = e0; ev_node = e1; ev_fault_a = e2; ev_fault_b = e3;
    for (int s = 0; s < 4; s++) begin
      if (we && a == 12'h018 + 12'(4*s)) m_en[s] = d[15:0];
      if (we && a == 12'h600 + 12'(8*s)) m_raw[s] = m_raw[s] & ~d[15:0];
      m_raw[s] = m_raw[s] | evs[s];
    end
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
    ev_end = '0; ev_node = '0; ev_fault_a = '0; ev_fault_b = '0;
  endtask

  task automatic idle_write(input logic [11:0] a, input logic [31:0] d);
    cycle(1'b1, a, d, '0, '0, '0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [11:0] addrs [16];
    addrs = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h018, 12'h01C, 12'h020,
              12'h024, 12'h600, 12'h608, 12'h610, 12'h618, 12'h014, 12'h604, 12'h700};
    for (int s = 0; s < 4; s++) begin m_raw[s] = '0; m_en[s] = '0; end
    void'($urandom(32'd1234));

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 13; i++) check_reg("R1 reset reg", addrs[i]);
    check("R1 irq after reset", {31'h0, irq}, 32'h0);

    // R2/R4: latched while disabled, not visible in views
    cycle(1'b0, 12'h0, 0, 16'h0008, '0, '0, '0);
    check_reg("R2 end latch", 12'h600);
    check("R2 end latch value", reg_rdata, 32'h8);
    check_reg("R4 view masked", 12'h004);
    check("R6 irq masked", {31'h0, irq}, 32'h0);

    // R3/R4/R5/R6: enable all end-of-chain
    idle_write(12'h018, 32'h0000_FFFF);
    check_reg("R3 enable readback", 12'h018);
    check_reg("R4 view after enable", 12'h004);
    check_reg("R5 summary", 12'h000);
    check("R6 irq raised", {31'h0, irq}, 32'h1);

    // R7: clearing bit 3 plus an idle bit, neighbours kept
    cycle(1'b0, 12'h0, 0, 16'h0100, '0, '0, '0);
    idle_write(12'h600, 32'h0000_0009);
    check_reg("R7 partial clear", 12'h600);
    check("R7 bit 8 kept", reg_rdata, 32'h100);
    idle_write(12'h600, 32'h0000_0100);
    check("R6 irq falls", {31'h0, irq}, 32'h0);

    // R8: event and clear on the same bit
    idle_write(12'h01C, 32'h0000_0020);
    cycle(1'b1, 12'h608, 32'h20, '0, 16'h0020, '0, '0);
    check_reg("R8 event wins", 12'h608);
    check("R8 bit kept", reg_rdata, 32'h20);
    check("R8 irq stays", {31'h0, irq}, 32'h1);
    idle_write(12'h608, 32'h20);

    // R9: stray writes
    cycle(1'b0, 12'h0, 0, '0, '0, 16'h0001, '0);
    idle_write(12'h000, 32'hFFFF_FFFF);
    idle_write(12'h00C, 32'hFFFF_FFFF);
    idle_write(12'h700, 32'hFFFF_FFFF);
    idle_write(12'h014, 32'hFFFF_FFFF);
    for (int i = 0; i < 16; i++) check_reg("R9 stray write", addrs[i]);
    reg_addr = 12'h700; #1;
    check("R9 unmapped read", reg_rdata, 32'h0);

    // R10 and R5: upper bits dropped, channel 15 and fault B on channel 0
    idle_write(12'h024, 32'hFFFF_FFFF);
    check_reg("R10 upper enable bits", 12'h024);
    check("R10 enable value", reg_rdata, 32'h0000_FFFF);
    cycle(1'b0, 12'h0, 0, '0, '0, '0, 16'h8001);
    check_reg("R10 channel 15", 12'h010);
    check("R10 view value", reg_rdata, 32'h8001);
    check_reg("R5 summary fault", 12'h000);

    // random phase
    for (int n = 0; n < 600; n++) begin
      logic [11:0] a;
      logic [15:0] e [4];
      logic we;
      a  = addrs[$urandom_range(15, 0)];
      we = ($urandom_range(2, 0) == 0);
      for (int s = 0; s < 4; s++)
        e[s] = ($urandom_range(3, 0) == 0) ? 16'($urandom & $urandom) : 16'h0;
      cycle(we, a, $urandom, e[0], e[1], e[2], e[3]);
      check("R6 random irq", {31'h0, irq}, {31'h0, |m_sum()});
      check_reg("R4 R5 R7 random read", addrs[$urandom_range(15, 0)]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule